// File: doc/BRIEF.md
# Instruction Fetch Front End

This block sits at the head of a 32-bit in-order core. It keeps the fetch address, presents it to a byte-organised instruction store, and builds a 32-bit instruction word from the four bytes that come back, least significant byte first. Each fetched word goes into a single output register together with its own address and that address plus four. Decode reads this register. Decode uses the address-plus-four as the link value when it writes the destination register of a jump-and-link.

In the same cycle, decode reports back whether the instruction it holds is a taken conditional branch or a jump-and-link, and gives the address of that instruction. The block extracts the branch or jump offset from the held instruction word. It adds the offset to the reported address, moves the fetch address there, and invalidates the output register for one cycle so that the wrongly fetched sequential word is dropped. While the stall input is high and there is no redirect, the fetch address and the output register both stay as they are. A redirect overrides a stall.

The output register works as a stream with a plain valid flag. There is no ready input: back-pressure from decode comes only through the stall pin, and a stalled word stays on the outputs unchanged until stall drops.

Top module: `ifetch_front`

## Requirements
- R1: While reset is asserted (active low), and at the first sample after it is released, `imem_addr` is 0 and `dec_valid` is 0.
- R2: In a cycle with no stall and no accepted redirect, `imem_addr` advances by 4. The output register loads the word fetched from the old address, with `dec_pc` set to the old address and `dec_valid` set to 1.
- R3: `dec_inst` bits [8k+7:8k] equal the byte at address `dec_pc`+k, for k = 0..3. Byte lane k of `imem_rdata` carries the byte at `imem_addr`+k.
- R4: With `stall` high and no accepted redirect, `imem_addr`, `dec_valid`, `dec_inst`, `dec_pc` and `dec_pc4` all keep their values.
- R5: If `dec_valid` is 1, `br_taken` is 1 and `dec_inst[6:0]` is 1100011, the next `imem_addr` is `br_pc` plus the sign-extended offset. The offset takes bit 12 from inst[31], bits 10:5 from inst[30:25], bits 4:1 from inst[11:8] and bit 11 from inst[7], and bit 0 is 0.
- R6: If `dec_valid` is 1, `jump` is 1 and `dec_inst[6:0]` is 1101111, the next `imem_addr` is `br_pc` plus the sign-extended offset. The offset takes bit 20 from inst[31], bits 10:1 from inst[30:21], bit 11 from inst[20] and bits 19:12 from inst[19:12], and bit 0 is 0.
- R7: The cycle after an accepted redirect, `dec_valid` is 0.
- R8: An accepted redirect is taken even when `stall` is high in the same cycle.
- R9: `br_taken` and `jump` have no effect when the held opcode does not match the flag, or when `dec_valid` is 0. In that case the block behaves as described in R2 or R4.
- R10: Whenever `dec_valid` is 1, `dec_pc4` equals `dec_pc` + 4, and this value is the link value for a jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Hold the fetch address and the output register |
| br_taken | input | 1 | The held instruction is a branch and its condition is met |
| jump | input | 1 | The held instruction is a jump-and-link |
| br_pc | input | 32 | Address of the instruction that decode is resolving |
| imem_addr | output | 32 | Byte address of the current fetch |
| imem_rdata | input | 32 | Four bytes from the store; lane k is the byte at imem_addr+k |
| dec_valid | output | 1 | The output register holds a live instruction |
| dec_inst | output | 32 | Assembled instruction word |
| dec_pc | output | 32 | Address of dec_inst |
| dec_pc4 | output | 32 | dec_pc + 4, used as the link value |

## Verification
A corrupted fetch address shows up on `imem_addr` in the very next sample, because the port is the register itself. One cycle later the same error reaches `dec_pc` and `dec_inst`. A wrong redirect decision, such as a missed opcode match or a stall winning over a redirect, shows at once as a wrong next address and as `dec_valid` staying high. A scrambled offset bit moves the target by a power of two, so comparing every sampled address against a model that follows the requirements catches it within one cycle of the redirect. A lane swap in the word assembly shows in `dec_inst` on every valid cycle.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned OPC_W    = 7;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [1:0] {
    NX_SEQ   = 2'd0,
    NX_HOLD  = 2'd1,
    NX_BRTGT = 2'd2,
    NX_JTGT  = 2'd3
  } nx_src_e;
endpackage

// File: rtl/ifetch_imm_gen.sv
module ifetch_imm_gen
  import ifetch_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] inst,
  output logic [W-1:0] b_off,
  output logic [W-1:0] j_off,
  output logic         is_branch,
  output logic         is_jal
);
  localparam int unsigned B_BITS = 13;
  localparam int unsigned J_BITS = 21;

  logic [B_BITS-1:0] b_raw;
  logic [J_BITS-1:0] j_raw;

  always_comb begin
    b_raw = {inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
    j_raw = {inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
    b_off = {{(W-B_BITS){b_raw[B_BITS-1]}}, b_raw};
    j_off = {{(W-J_BITS){j_raw[J_BITS-1]}}, j_raw};
    is_branch = (inst[OPC_W-1:0] == OPC_BRANCH);
    is_jal    = (inst[OPC_W-1:0] == OPC_JAL);
  end
endmodule

// File: rtl/ifetch_word_pack.sv
module ifetch_word_pack #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*8-1:0] lanes,
  output logic [LANES*8-1:0] word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // lane k is the byte at (address + k): lowest address lands in the low byte
    assign word[8*k +: 8] = lanes[8*k +: 8];
  end
endmodule

// File: rtl/ifetch_pc_sel.sv
module ifetch_pc_sel
  import ifetch_pkg::*;
#(
  parameter int unsigned W    = XLEN,
  parameter int unsigned STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pc_q,
  input  logic         held_valid,
  input  logic         stall,
  input  logic         br_taken,
  input  logic         jump,
  input  logic         is_branch,
  input  logic         is_jal,
  input  logic [W-1:0] br_pc,
  input  logic [W-1:0] b_off,
  input  logic [W-1:0] j_off,
  output logic [W-1:0] pc_next,
  output logic         redirect
);
  nx_src_e src;

  always_comb begin
    if (held_valid && jump && is_jal)              src = NX_JTGT;
    else if (held_valid && br_taken && is_branch)  src = NX_BRTGT;
    else if (stall)                                src = NX_HOLD;
    else                                           src = NX_SEQ;
  end

  always_comb begin
    unique case (src)
      NX_JTGT:  pc_next = br_pc + j_off;
      NX_BRTGT: pc_next = br_pc + b_off;
      NX_HOLD:  pc_next = pc_q;
      default:  pc_next = pc_q + W'(STEP);
    endcase
    redirect = (src == NX_JTGT) || (src == NX_BRTGT);
  end

  p_redirect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && br_taken && is_branch && stall) |-> redirect);

  p_ignore_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_valid || (!(br_taken && is_branch) && !(jump && is_jal))) |-> !redirect);
endmodule

// File: rtl/ifetch_front.sv
module ifetch_front
  import ifetch_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned LANES = W / 8,
  parameter int unsigned STEP  = LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         br_taken,
  input  logic         jump,
  input  logic [W-1:0] br_pc,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_rdata,
  output logic         dec_valid,
  output logic [W-1:0] dec_inst,
  output logic [W-1:0] dec_pc,
  output logic [W-1:0] dec_pc4
);
  logic [W-1:0] pc_q, pc_next, word;
  logic [W-1:0] b_off, j_off;
  logic         is_branch, is_jal, redirect;

  ifetch_word_pack #(.LANES(LANES)) i_pack (
    .lanes (imem_rdata),
    .word  (word)
  );

  ifetch_imm_gen #(.W(W)) i_imm (
    .inst      (dec_inst),
    .b_off     (b_off),
    .j_off     (j_off),
    .is_branch (is_branch),
    .is_jal    (is_jal)
  );

  ifetch_pc_sel #(.W(W), .STEP(STEP)) i_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_q       (pc_q),
    .held_valid (dec_valid),
    .stall      (stall),
    .br_taken   (br_taken),
    .jump       (jump),
    .is_branch  (is_branch),
    .is_jal     (is_jal),
    .br_pc      (br_pc),
    .b_off      (b_off),
    .j_off      (j_off),
    .pc_next    (pc_next),
    .redirect   (redirect)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_inst  <= '0;
      dec_pc    <= '0;
      dec_pc4   <= '0;
    end else if (redirect) begin
      dec_valid <= 1'b0;
    end else if (!stall) begin
      dec_valid <= 1'b1;
      dec_inst  <= word;
      dec_pc    <= pc_q;
      dec_pc4   <= pc_q + W'(STEP);
    end
  end

  assign imem_addr = pc_q;

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> (pc_q == $past(pc_q) + W'(STEP)) && dec_valid);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> $stable(pc_q) && $stable(dec_inst) && $stable(dec_valid));

  p_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !dec_valid);

  p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_pc4 == dec_pc + W'(STEP)));
endmodule

// File: tb/test_ifetch_front.sv
`timescale 1ns/1ps
module test_ifetch_front;
  localparam int NCYC = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0, br_taken = 1'b0, jump = 1'b0;
  logic [31:0] br_pc = '0;
  logic [31:0] imem_addr, imem_rdata;
  logic        dec_valid;
  logic [31:0] dec_inst, dec_pc, dec_pc4;

  logic [7:0]  mem [256];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ifetch_front i_ifetch_front (
    .clk(clk), .rst_n(rst_n), .stall(stall), .br_taken(br_taken), .jump(jump),
    .br_pc(br_pc), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dec_valid(dec_valid), .dec_inst(dec_inst), .dec_pc(dec_pc), .dec_pc4(dec_pc4)
  );

  always_comb
    imem_rdata = {mem[8'(imem_addr + 3)], mem[8'(imem_addr + 2)],
                  mem[8'(imem_addr + 1)], mem[8'(imem_addr)]};

  function automatic logic [31:0] fetch_word(input logic [31:0] a);
    return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
  endfunction

  function automatic logic [31:0] boff(input logic [31:0] i);
    logic [31:0] v = '0;
    v[12] = i[31]; v[10:5] = i[30:25]; v[4:1] = i[11:8]; v[11] = i[7];
    v[31:13] = {19{i[31]}};
    return v;
  endfunction

  function automatic logic [31:0] joff(input logic [31:0] i);
    logic [31:0] v = '0;
    v[20] = i[31]; v[10:1] = i[30:21]; v[11] = i[20]; v[19:12] = i[19:12];
    v[31:21] = {11{i[31]}};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // bench model state
  logic [31:0] m_pc = '0, m_inst = '0, m_dpc = '0, m_dpc4 = '0;
  logic        m_valid = 1'b0;
  string       addr_tag = "R1";

  initial begin
    for (int w = 0; w < 64; w++) begin
      int sel;
      for (int b = 1; b < 4; b++) mem[4*w+b] = 8'($urandom);
      sel = $urandom % 4;
      mem[4*w] = {1'($urandom), (sel == 0) ? 7'b1100011 : (sel == 1) ? 7'b1101111 : 7'($urandom)};
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", imem_addr, 32'h0);
    chk("R1 valid in reset", {31'd0, dec_valid}, 32'h0);
    rst_n = 1'b1;
    chk("R1 addr after release", imem_addr, 32'h0);
    chk("R1 valid after release", {31'd0, dec_valid}, 32'h0);

    for (int c = 0; c < NCYC; c++) begin
      logic acc_b, acc_j, redir;
      int r;
      // drive stimulus; a few directed phases mixed with random
      r = $urandom % 100;
      if (c >= 100 && c < 140) begin
        // directed: redirect attempts always paired with stall (R8)
        stall = 1'b1; br_taken = 1'b1; jump = 1'b1;
      end else if (c >= 200 && c < 230) begin
        // directed: flags up without stall, mostly mismatched opcodes (R9)
        stall = 1'b0; br_taken = 1'b1; jump = 1'b0;
      end else begin
        stall    = (r < 25);
        br_taken = ($urandom % 100) < 30;
        jump     = ($urandom % 100) < 20;
      end
      br_pc = ($urandom % 4 == 0) ? $urandom : m_dpc;

      acc_j = m_valid && jump && (m_inst[6:0] == 7'b1101111);
      acc_b = m_valid && br_taken && (m_inst[6:0] == 7'b1100011);
      redir = acc_j || acc_b;

      @(posedge clk);
      // model update
      if (redir) begin
        m_valid = 1'b0;
        m_pc = br_pc + (acc_j ? joff(m_inst) : boff(m_inst));
        addr_tag = stall ? "R8 redirect over stall" : (acc_j ? "R6 jump target" : "R5 branch target");
      end else if (!stall) begin
        m_valid = 1'b1;
        m_inst  = fetch_word(m_pc);
        m_dpc   = m_pc;
        m_dpc4  = m_pc + 4;
        m_pc    = m_pc + 4;
        addr_tag = (br_taken || jump) ? "R9 flags ignored" : "R2 sequential";
      end else begin
        addr_tag = (br_taken || jump) ? "R9 ignored under stall" : "R4 stall hold";
      end

      @(negedge clk);
      chk(addr_tag, imem_addr, m_pc);
      chk(redir ? "R7 squash" : "R2 valid", {31'd0, dec_valid}, {31'd0, m_valid});
      if (m_valid) begin
        chk(stall ? "R4 inst held" : "R3 inst assembly", dec_inst, m_inst);
        chk("R2 dec_pc", dec_pc, m_dpc);
        chk("R10 link value", dec_pc4, m_dpc4);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule